// File: doc/BRIEF.md
# Slot Event Interrupt Locator

This block collects the event state of a seven-slot hot-plug controller and turns it into two read-only 32-bit locator words. Software reads one word to see which sources raise an ordinary interrupt and the other to see which raise a system-error (SERR) report. Each slot has four event latches: attention button, presence change, power fault and MRL sensor change. A detection pulse sets a latch, and software clears it by writing 1 to its position. Each latch bit has its own interrupt mask bit and its own SERR mask bit.

Bit 0 of each locator comes from a controller-level source. For the interrupt word this is command completion, gated by its own mask. For the SERR word it is arbiter timeout, gated by its own mask. Bits 7:1 carry one bit per slot, and bits 31:8 stay zero. The locator bits are worked out every cycle from the current latches and masks. A mask change therefore shows up at once, and no latch has to be cleared for it. Two registered summary lines give the OR of each locator word.

Top module: `slot_event_locator`

## Requirements
- R1: After a synchronous reset, all event latches, both locator words and both summary outputs read zero.
- R2: Bits 31:8 of `int_locator` and `serr_locator` always read zero.
- R3: A 1 on `evt_det[s*4+e]` sets latch bit `evt_latch[s*4+e]` at the next clock edge. Here s is the slot (0..6) and e is the event: 0 attention button, 1 presence change, 2 power fault, 3 MRL sensor change. A set latch bit holds until it is cleared.
- R4: A 1 on `evt_clr[i]` clears latch bit i at the next edge and leaves the other bits unchanged. If `evt_det[i]` is 1 in the same cycle, the bit stays set.
- R5: `int_locator[s+1]` is 1 while slot s has at least one latched event whose `evt_int_mask` bit (same index) is 0. Several slot bits can be 1 at once.
- R6: A slot's interrupt locator bit stays set while any unmasked latched event of that slot remains. It drops only when the last one is cleared.
- R7: `serr_locator[s+1]` is 1 while slot s has a latched power-fault (e=2) or MRL (e=3) event whose `evt_serr_mask` bit is 0. Attention-button and presence events never set it.
- R8: `int_locator[0]` equals `cmd_done` AND NOT `cmd_int_mask`.
- R9: `serr_locator[0]` equals `arb_timeout` AND NOT `arb_serr_mask`.
- R10: A change of a mask bit changes the locator words in the same cycle, with the latch unchanged.
- R11: `int_req` and `serr_req` equal the OR of `int_locator` and of `serr_locator` as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_det | input | 28 | Event detection pulses, index slot*4+event |
| evt_clr | input | 28 | Write-1-to-clear strobes, same indexing |
| evt_int_mask | input | 28 | Per-event interrupt mask, 1 = masked |
| evt_serr_mask | input | 28 | Per-event SERR mask, 1 = masked |
| cmd_done | input | 1 | Command completion detected flag |
| cmd_int_mask | input | 1 | Command completion interrupt mask |
| arb_timeout | input | 1 | Arbiter timeout detected flag |
| arb_serr_mask | input | 1 | Arbiter timeout SERR mask |
| evt_latch | output | 28 | Current event latch contents |
| int_locator | output | 32 | Interrupt locator word |
| serr_locator | output | 32 | SERR locator word |
| int_req | output | 1 | Registered OR of the interrupt locator |
| serr_req | output | 1 | Registered OR of the SERR locator |

## Verification
The latch is the only state that feeds the locators. A latch bit that is stuck, or one that is cleared when it should not be, therefore shows up on `evt_latch` and on the matching locator bit one edge after the pulse or strobe. A fault in the masking or the slot-to-bit mapping changes a locator bit in the same cycle as the input change. A fault in the summary registers shows on `int_req` or `serr_req` one edge later. The bench puts single events on every slot and event kind under different mask settings. It also covers several slots at once, partial clears, a detect and a clear in the same cycle, and live mask flips.

// File: rtl/slot_loc_pkg.sv
package slot_loc_pkg;
    localparam int EVT_W = 4;
    localparam int LOC_W = 32;

    typedef enum int unsigned {
        EV_BUTTON   = 0,
        EV_PRESENCE = 1,
        EV_PFAULT   = 2,
        EV_MRL      = 3
    } evt_kind_e;

    // events that may raise a system error
    localparam logic [EVT_W-1:0] SERR_CAPABLE =
        (EVT_W'(1) << EV_PFAULT) | (EVT_W'(1) << EV_MRL);

    typedef struct packed {
        logic intr;
        logic serr;
    } pend_t;

    function automatic logic any_live(input logic [EVT_W-1:0] lat,
                                      input logic [EVT_W-1:0] msk,
                                      input logic [EVT_W-1:0] sel);
        return |(lat & ~msk & sel);
    endfunction
endpackage

// File: rtl/slot_event_latch.sv
module slot_event_latch
    import slot_loc_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] det,
    input  logic [W-1:0] clr,
    output logic [W-1:0] lat
);
    // detection wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) lat <= '0;
        else     lat <= (lat & ~clr) | det;
    end
endmodule

// File: rtl/slot_pending.sv
module slot_pending
    import slot_loc_pkg::*;
(
    input  logic [EVT_W-1:0] lat,
    input  logic [EVT_W-1:0] int_msk,
    input  logic [EVT_W-1:0] serr_msk,
    output pend_t            pend
);
    always_comb begin
        pend.intr = any_live(lat, int_msk, '1);
        pend.serr = any_live(lat, serr_msk, SERR_CAPABLE);
    end
endmodule

// File: rtl/locator_compose.sv
module locator_compose
    import slot_loc_pkg::*;
#(
    parameter int NUM_SLOTS = 7
) (
    input  logic [NUM_SLOTS-1:0] slot_int,
    input  logic [NUM_SLOTS-1:0] slot_serr,
    input  logic                 ctl_int,
    input  logic                 ctl_serr,
    output logic [LOC_W-1:0]     int_loc,
    output logic [LOC_W-1:0]     serr_loc
);
    localparam int PAD_W = LOC_W - NUM_SLOTS - 1;

    always_comb begin
        int_loc  = {{PAD_W{1'b0}}, slot_int,  ctl_int};
        serr_loc = {{PAD_W{1'b0}}, slot_serr, ctl_serr};
    end
endmodule

// File: rtl/slot_event_locator.sv
module slot_event_locator
    import slot_loc_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    localparam int EV_TOTAL = NUM_SLOTS * EVT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [EV_TOTAL-1:0] evt_det,
    input  logic [EV_TOTAL-1:0] evt_clr,
    input  logic [EV_TOTAL-1:0] evt_int_mask,
    input  logic [EV_TOTAL-1:0] evt_serr_mask,
    input  logic                cmd_done,
    input  logic                cmd_int_mask,
    input  logic                arb_timeout,
    input  logic                arb_serr_mask,
    output logic [EV_TOTAL-1:0] evt_latch,
    output logic [LOC_W-1:0]    int_locator,
    output logic [LOC_W-1:0]    serr_locator,
    output logic                int_req,
    output logic                serr_req
);
    logic [NUM_SLOTS-1:0] slot_int;
    logic [NUM_SLOTS-1:0] slot_serr;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        pend_t pend;

        slot_event_latch #(.W(EVT_W)) u_latch (
            .clk (clk),
            .rst (rst),
            .det (evt_det[s*EVT_W +: EVT_W]),
            .clr (evt_clr[s*EVT_W +: EVT_W]),
            .lat (evt_latch[s*EVT_W +: EVT_W])
        );

        slot_pending u_pend (
            .lat      (evt_latch[s*EVT_W +: EVT_W]),
            .int_msk  (evt_int_mask[s*EVT_W +: EVT_W]),
            .serr_msk (evt_serr_mask[s*EVT_W +: EVT_W]),
            .pend     (pend)
        );

        assign slot_int[s]  = pend.intr;
        assign slot_serr[s] = pend.serr;
    end

    locator_compose #(.NUM_SLOTS(NUM_SLOTS)) u_compose (
        .slot_int  (slot_int),
        .slot_serr (slot_serr),
        .ctl_int   (cmd_done & ~cmd_int_mask),
        .ctl_serr  (arb_timeout & ~arb_serr_mask),
        .int_loc   (int_locator),
        .serr_loc  (serr_locator)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_req  <= 1'b0;
            serr_req <= 1'b0;
        end else begin
            int_req  <= |int_locator;
            serr_req <= |serr_locator;
        end
    end
endmodule

// File: rtl/slot_locator_checker.sv
module slot_locator_checker
    import slot_loc_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    localparam int EV_TOTAL = NUM_SLOTS * EVT_W
) (
    input logic                clk,
    input logic                rst,
    input logic [EV_TOTAL-1:0] evt_det,
    input logic [EV_TOTAL-1:0] evt_clr,
    input logic                cmd_done,
    input logic                cmd_int_mask,
    input logic                arb_timeout,
    input logic                arb_serr_mask,
    input logic [EV_TOTAL-1:0] evt_latch,
    input logic [LOC_W-1:0]    int_locator,
    input logic [LOC_W-1:0]    serr_locator,
    input logic                int_req,
    input logic                serr_req
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (evt_latch == '0 && !int_req && !serr_req));

    // R2
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (int_locator[LOC_W-1:NUM_SLOTS+1] == '0) &&
        (serr_locator[LOC_W-1:NUM_SLOTS+1] == '0));

    // R3
    a_r3_detect_sets: assert property (@(posedge clk) disable iff (rst)
        (|evt_det) |=> ((evt_latch & $past(evt_det)) == $past(evt_det)));

    a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(evt_latch) & ~$past(evt_clr) & ~evt_latch) == '0));

    // R4
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (|evt_clr) |=> ((evt_latch & $past(evt_clr & ~evt_det)) == '0));

    // R8
    a_r8_cmd_bit: assert property (@(posedge clk) disable iff (rst)
        int_locator[0] == (cmd_done && !cmd_int_mask));

    // R9
    a_r9_arb_bit: assert property (@(posedge clk) disable iff (rst)
        serr_locator[0] == (arb_timeout && !arb_serr_mask));

    // R11
    a_r11_int_summary: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int_req == (|$past(int_locator))));

    a_r11_serr_summary: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (serr_req == (|$past(serr_locator))));
endmodule

bind slot_event_locator slot_locator_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .evt_det       (evt_det),
    .evt_clr       (evt_clr),
    .cmd_done      (cmd_done),
    .cmd_int_mask  (cmd_int_mask),
    .arb_timeout   (arb_timeout),
    .arb_serr_mask (arb_serr_mask),
    .evt_latch     (evt_latch),
    .int_locator   (int_locator),
    .serr_locator  (serr_locator),
    .int_req       (int_req),
    .serr_req      (serr_req)
);

// File: tb/test_slot_event_locator.sv
module test_slot_event_locator;
    localparam int NS = 7;
    localparam int EW = 4;
    localparam int NT = NS * EW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] evt_det = '0, evt_clr = '0;
    logic [NT-1:0] evt_int_mask = '1, evt_serr_mask = '1;
    logic          cmd_done = 1'b0, cmd_int_mask = 1'b1;
    logic          arb_timeout = 1'b0, arb_serr_mask = 1'b1;
    logic [NT-1:0] evt_latch;
    logic [31:0]   int_locator, serr_locator;
    logic          int_req, serr_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slot_event_locator #(.NUM_SLOTS(NS)) i_slot_event_locator (
        .clk(clk), .rst(rst), .evt_det(evt_det), .evt_clr(evt_clr),
        .evt_int_mask(evt_int_mask), .evt_serr_mask(evt_serr_mask),
        .cmd_done(cmd_done), .cmd_int_mask(cmd_int_mask),
        .arb_timeout(arb_timeout), .arb_serr_mask(arb_serr_mask),
        .evt_latch(evt_latch), .int_locator(int_locator),
        .serr_locator(serr_locator), .int_req(int_req), .serr_req(serr_req)
    );

    typedef struct packed {
        logic [7:0] slot;
        logic [7:0] ev;
        logic       im;
        logic       sm;
        logic [7:0] exp_int;
        logic [7:0] exp_serr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TABLE [NV] = '{
        '{8'd0, 8'd0, 1'b0, 1'b0, 8'h02, 8'h00},
        '{8'd3, 8'd2, 1'b0, 1'b0, 8'h10, 8'h10},
        '{8'd6, 8'd3, 1'b0, 1'b0, 8'h80, 8'h80},
        '{8'd2, 8'd1, 1'b1, 1'b0, 8'h00, 8'h00},
        '{8'd5, 8'd2, 1'b1, 1'b0, 8'h00, 8'h40},
        '{8'd4, 8'd3, 1'b0, 1'b1, 8'h20, 8'h00},
        '{8'd1, 8'd0, 1'b0, 1'b0, 8'h04, 8'h00},
        '{8'd1, 8'd2, 1'b1, 1'b1, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // one clock: inputs set at a negedge, then observe at the next negedge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        evt_clr = '1;
        tick();
        evt_clr = '0;
    endtask

    task automatic pulse(input logic [NT-1:0] d);
        evt_det = d;
        tick();
        evt_det = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 latch", 64'(evt_latch), 64'h0);
        chk("R1 int_locator", 64'(int_locator), 64'h0);
        chk("R1 serr_locator", 64'(serr_locator), 64'h0);
        chk("R1 req", 64'({int_req, serr_req}), 64'h0);
        rst = 1'b0;
        tick();

        // table walk: R3, R5, R7
        for (int v = 0; v < NV; v++) begin
            int idx;
            idx = int'(TABLE[v].slot) * EW + int'(TABLE[v].ev);
            clear_all();
            evt_int_mask = '1;
            evt_serr_mask = '1;
            evt_int_mask[idx] = TABLE[v].im;
            evt_serr_mask[idx] = TABLE[v].sm;
            pulse(NT'(1) << idx);
            chk("R3 latch set", 64'(evt_latch), 64'(NT'(1) << idx));
            chk("R5 int_locator", 64'(int_locator), 64'(TABLE[v].exp_int));
            chk("R7 serr_locator", 64'(serr_locator), 64'(TABLE[v].exp_serr));
            tick();
            chk("R11 int_req", 64'(int_req), 64'(TABLE[v].exp_int != 0));
            chk("R11 serr_req", 64'(serr_req), 64'(TABLE[v].exp_serr != 0));
        end

        // R5/R7: several slots at once (power fault on slots 0, 2, 6)
        clear_all();
        evt_int_mask = '0;
        evt_serr_mask = '0;
        pulse((NT'(1) << 2) | (NT'(1) << 10) | (NT'(1) << 26));
        chk("R5 multi slot", 64'(int_locator), 64'h8A);
        chk("R7 multi slot", 64'(serr_locator), 64'h8A);
        chk("R2 reserved", 64'({int_locator[31:8], serr_locator[31:8]}), 64'h0);

        // R6: slot 3 button and presence, partial clear keeps bit 4
        clear_all();
        pulse((NT'(1) << 12) | (NT'(1) << 13));
        chk("R6 both set", 64'(int_locator), 64'h10);
        evt_clr = NT'(1) << 12;
        tick();
        evt_clr = '0;
        chk("R6 partial clear", 64'(int_locator), 64'h10);
        chk("R4 other bit kept", 64'(evt_latch), 64'(NT'(1) << 13));
        chk("R7 button presence no serr", 64'(serr_locator), 64'h0);
        evt_clr = NT'(1) << 13;
        tick();
        evt_clr = '0;
        chk("R6 last clear", 64'(int_locator), 64'h0);

        // R4: detect and clear same cycle on slot 0 button, MRL untouched
        clear_all();
        pulse((NT'(1) << 0) | (NT'(1) << 3));
        evt_det = NT'(1) << 0;
        evt_clr = (NT'(1) << 0);
        tick();
        evt_det = '0;
        evt_clr = '0;
        chk("R4 detect wins", 64'(evt_latch), 64'(9));
        evt_clr = NT'(1) << 0;
        tick();
        evt_clr = '0;
        chk("R4 clear one", 64'(evt_latch), 64'(8));

        // R10: live mask change, slot 1 button latched
        clear_all();
        evt_int_mask = '1;
        pulse(NT'(1) << 4);
        chk("R10 masked", 64'(int_locator), 64'h0);
        tick();
        chk("R11 req low", 64'(int_req), 64'h0);
        evt_int_mask[4] = 1'b0;
        #1;
        chk("R10 unmask same cycle", 64'(int_locator), 64'h04);
        chk("R11 req not yet", 64'(int_req), 64'h0);
        tick();
        chk("R11 req follows", 64'(int_req), 64'h1);
        chk("R10 latch unchanged", 64'(evt_latch), 64'(NT'(1) << 4));
        clear_all();
        evt_int_mask = '1;

        // R8: command complete bit
        cmd_done = 1'b1;
        cmd_int_mask = 1'b0;
        #1;
        chk("R8 cmd unmasked", 64'(int_locator), 64'h1);
        cmd_int_mask = 1'b1;
        #1;
        chk("R8 cmd masked", 64'(int_locator), 64'h0);
        cmd_done = 1'b0;

        // R9: arbiter timeout bit
        arb_timeout = 1'b1;
        arb_serr_mask = 1'b0;
        #1;
        chk("R9 arb unmasked", 64'(serr_locator), 64'h1);
        chk("R9 no int", 64'(int_locator), 64'h0);
        tick();
        chk("R11 serr_req", 64'(serr_req), 64'h1);
        arb_serr_mask = 1'b1;
        #1;
        chk("R9 arb masked", 64'(serr_locator), 64'h0);
        arb_timeout = 1'b0;

        // R1: reset clears held latches
        pulse(NT'(1) << 27);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset latch", 64'(evt_latch), 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule